// File: doc/BRIEF.md
# Transfer Descriptor Status Update Unit

This block takes one transfer descriptor at a time and returns its updated status. For each descriptor it receives the 32-bit control word, the 32-bit token word and the outcome of the bus transaction. The outcome is a byte count, a stall, babble, a NAK, a timeout or no-device, or "still in flight". From these it produces four things: the rewritten control word, a mask of interrupt causes, a result code, and the fields decoded from the token. The schedule walker uses the result code to decide whether to advance, skip, wait or abandon the frame. Memory access, data movement and walking the schedule are done elsewhere.

Requests enter through a valid/ready handshake and leave through a second one. A single register stage sits between them, so a result appears on the cycle after the request is accepted. That result stays on the outputs until the consumer takes it.

Top module: `tdStatusUnit`

## Requirements
- R1: The token decodes as follows: PID is bits 7:0, device address is bits 14:8, endpoint is bits 18:15, and maximum length is (bits 31:21 + 1) modulo 2048, so 0x7FF means zero bytes. `outBadPid` is 1 unless the PID is 0x2D (SETUP), 0x69 (IN) or 0xE1 (OUT).
- R2: A request is accepted when `inValid` and `inReady` are both high, and its result is on the outputs with `outValid` high on the next cycle. While `outValid` is high and `outReady` is low, the outputs hold steady and `inReady` is low.
- R3: If the active bit (23) of the control word is clear, the control word passes through unchanged, no cause is raised and the result is skip. This holds even when the PID is invalid.
- R4: A byte-count outcome (kind 0) is a success. The unit writes (count − 1) modulo 2048 into bits 10:0, clears active (23) and NAK (19), and sets the result to done. It raises cause bit 0 (completion) if and only if interrupt-on-complete (bit 24) is set.
- R5: If short-packet detect (bit 29) is set and the count is below the maximum length, a success returns skip and raises cause bit 1 (short packet). A full-length count returns done.
- R6: On an IN PID, a count above the maximum length is handled as babble. On OUT or SETUP, the count is stored as sent.
- R7: A stall (kind 1) sets bit 22, clears active and returns skip.
- R8: Babble (kind 2) sets bits 20 and 22, clears active and returns fatal.
- R9: A NAK (kind 3) on IN or OUT sets bit 19, leaves the descriptor active and returns skip. A NAK on SETUP sets bit 19 and then follows the timeout rules of R10.
- R10: A timeout or no-device outcome (kind 4, and reserved kinds 6 and 7) sets bit 18 and returns skip. If the error counter (bits 28:27) is nonzero, it is decremented. When the decrement reaches zero, active is cleared, cause bit 2 (transaction error) is raised, and cause bit 0 is raised if bit 24 is set. A counter already at zero stays at zero and the descriptor stays active.
- R11: An isochronous descriptor (bit 25) has active cleared for every completing outcome (kinds 0–4, 6, 7).
- R12: An active descriptor with an invalid PID is left unchanged, raises cause bit 3 (process error) and returns fatal.
- R13: The in-flight outcome (kind 5) leaves the control word unchanged, raises no cause and returns pending.
- Result code encoding: 0 done, 1 skip, 2 pending, 3 fatal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Unit can accept a request |
| inCtrl | input | 32 | Descriptor control word |
| inToken | input | 32 | Descriptor token word |
| inKind | input | 3 | Transaction outcome kind (0 data, 1 stall, 2 babble, 3 NAK, 4 timeout, 5 in flight, 6/7 timeout) |
| inLen | input | 12 | Byte count returned by a data outcome |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer takes the result |
| outCtrl | output | 32 | Updated control word |
| outCause | output | 4 | Cause mask: bit0 completion, bit1 short, bit2 transaction error, bit3 process error |
| outResult | output | 2 | Result code |
| outPid | output | 8 | Decoded PID |
| outAddr | output | 7 | Decoded device address |
| outEndp | output | 4 | Decoded endpoint |
| outMaxLen | output | 11 | Decoded maximum length |
| outBadPid | output | 1 | PID is not SETUP, IN or OUT |

## Verification
The hardest situations to reach involve two rules meeting in one request:
- an error counter stepping from one to zero on a descriptor that also requests a completion interrupt;
- a NAK on a SETUP token, which must take the timeout path;
- an isochronous descriptor receiving a NAK;
- an IN count exactly one byte over the maximum.

None of these arise from typical traffic, so each is placed in the vector table as a hand-built control word and token with its expected word worked out bit by bit. The hold-under-backpressure behaviour is reached by lowering `outReady` while a second request waits at the input.

// File: rtl/tdStatusPkg.sv
package tdStatusPkg;
  localparam int CW_W    = 32;
  localparam int LEN_W   = 11;
  localparam int BYTE_W  = LEN_W + 1;
  localparam int ERR_W   = 2;
  localparam int CAUSE_W = 4;

  localparam int BIT_SPD   = 29;
  localparam int ERR_LO    = 27;
  localparam int ERR_HI    = ERR_LO + ERR_W - 1;
  localparam int BIT_ISO   = 25;
  localparam int BIT_IOC   = 24;
  localparam int BIT_ACT   = 23;
  localparam int BIT_STALL = 22;
  localparam int BIT_BAB   = 20;
  localparam int BIT_NAK   = 19;
  localparam int BIT_TO    = 18;

  localparam int TOK_MAX_LO = 21;
  localparam int TOK_EP_LO  = 15;
  localparam int TOK_EP_W   = 4;
  localparam int TOK_AD_LO  = 8;
  localparam int TOK_AD_W   = 7;
  localparam int PID_W      = 8;

  localparam logic [PID_W-1:0] PID_SETUP = 8'h2D;
  localparam logic [PID_W-1:0] PID_IN    = 8'h69;
  localparam logic [PID_W-1:0] PID_OUT   = 8'hE1;

  localparam int CZ_DONE  = 0;
  localparam int CZ_SHORT = 1;
  localparam int CZ_XERR  = 2;
  localparam int CZ_PROC  = 3;

  typedef enum logic [2:0] {
    OC_DATA, OC_STALL, OC_BABBLE, OC_NAK, OC_TIMEOUT, OC_PEND, OC_RSV6, OC_RSV7
  } outcome_e;

  typedef enum logic [1:0] {
    RES_DONE, RES_SKIP, RES_PEND, RES_FATAL
  } result_e;

  typedef struct packed {
    logic active;
    logic iso;
    logic ioc;
    logic spd;
    logic pidOk;
    logic pidIn;
    logic pidSetup;
    logic overMax;
    logic underMax;
    logic errZero;
    logic errOne;
  } tdFlags_t;

  typedef struct packed {
    logic               load;
    logic               clrActive;
    logic               clrNak;
    logic               setStall;
    logic               setBabble;
    logic               setNak;
    logic               setTimeout;
    logic               wrLen;
    logic               decErr;
    logic [CAUSE_W-1:0] cause;
    result_e            result;
  } tdStrobe_t;
endpackage

// File: rtl/tdTokenDecode.sv
module tdTokenDecode
  import tdStatusPkg::*;
(
  input  logic [CW_W-1:0]     token,
  output logic [PID_W-1:0]    pid,
  output logic [TOK_AD_W-1:0] devAddr,
  output logic [TOK_EP_W-1:0] endp,
  output logic [LEN_W-1:0]    maxLen,
  output logic                pidOk,
  output logic                pidIn,
  output logic                pidSetup
);
  logic unusedTokBits;

  assign pid      = token[PID_W-1:0];
  assign devAddr  = token[TOK_AD_LO +: TOK_AD_W];
  assign endp     = token[TOK_EP_LO +: TOK_EP_W];
  // length field is encoded as n-1; all-ones wraps to a zero-byte transfer
  assign maxLen   = token[TOK_MAX_LO +: LEN_W] + LEN_W'(1);
  assign pidIn    = (pid == PID_IN);
  assign pidSetup = (pid == PID_SETUP);
  assign pidOk    = pidIn || pidSetup || (pid == PID_OUT);
  assign unusedTokBits = ^token[TOK_MAX_LO-1:TOK_EP_LO+TOK_EP_W];
endmodule

// File: rtl/tdStatusCtrl.sv
module tdStatusCtrl
  import tdStatusPkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic      outReady,
  input  tdFlags_t  flags,
  input  outcome_e  kind,
  output logic      inReady,
  output logic      outValid,
  output tdStrobe_t strobe
);
  logic doBabble;
  logic doError;

  assign inReady = !outValid || outReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           outValid <= 1'b0;
    else if (strobe.load) outValid <= 1'b1;
    else if (outReady)    outValid <= 1'b0;
  end

  always_comb begin
    strobe        = '0;
    strobe.result = RES_SKIP;
    strobe.load   = inValid && inReady;
    doBabble      = 1'b0;
    doError       = 1'b0;

    if (!flags.active) begin
      strobe.result = RES_SKIP;
    end else if (!flags.pidOk) begin
      strobe.cause[CZ_PROC] = 1'b1;
      strobe.result         = RES_FATAL;
    end else if (kind == OC_PEND) begin
      strobe.result = RES_PEND;
    end else begin
      strobe.clrActive = flags.iso;
      unique case (kind)
        OC_DATA: begin
          if (flags.pidIn && flags.overMax) begin
            doBabble = 1'b1;
          end else begin
            strobe.wrLen          = 1'b1;
            strobe.clrActive      = 1'b1;
            strobe.clrNak         = 1'b1;
            strobe.cause[CZ_DONE] = flags.ioc;
            if (flags.spd && flags.underMax) begin
              strobe.cause[CZ_SHORT] = 1'b1;
              strobe.result          = RES_SKIP;
            end else begin
              strobe.result = RES_DONE;
            end
          end
        end
        OC_STALL: begin
          strobe.setStall  = 1'b1;
          strobe.clrActive = 1'b1;
          strobe.result    = RES_SKIP;
        end
        OC_BABBLE: doBabble = 1'b1;
        OC_NAK: begin
          strobe.setNak = 1'b1;
          if (flags.pidSetup) doError = 1'b1;
          else                strobe.result = RES_SKIP;
        end
        default: doError = 1'b1;
      endcase

      if (doBabble) begin
        strobe.setBabble = 1'b1;
        strobe.setStall  = 1'b1;
        strobe.clrActive = 1'b1;
        strobe.result    = RES_FATAL;
      end

      if (doError) begin
        strobe.setTimeout = 1'b1;
        strobe.result     = RES_SKIP;
        if (!flags.errZero) begin
          strobe.decErr = 1'b1;
          if (flags.errOne) begin
            strobe.clrActive      = 1'b1;
            strobe.cause[CZ_XERR] = 1'b1;
            strobe.cause[CZ_DONE] = flags.ioc;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdStatusPath.sv
module tdStatusPath
  import tdStatusPkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW_W-1:0]     inCtrl,
  input  logic [CW_W-1:0]     inToken,
  input  logic [BYTE_W-1:0]   inLen,
  input  tdStrobe_t           strobe,
  output tdFlags_t            flags,
  output logic [CW_W-1:0]     outCtrl,
  output logic [CAUSE_W-1:0]  outCause,
  output result_e             outResult,
  output logic [PID_W-1:0]    outPid,
  output logic [TOK_AD_W-1:0] outAddr,
  output logic [TOK_EP_W-1:0] outEndp,
  output logic [LEN_W-1:0]    outMaxLen,
  output logic                outBadPid
);
  logic [PID_W-1:0]    decPid;
  logic [TOK_AD_W-1:0] decAddr;
  logic [TOK_EP_W-1:0] decEndp;
  logic [LEN_W-1:0]    decMax;
  logic                decPidOk;
  logic                decPidIn;
  logic                decPidSetup;
  logic [ERR_W-1:0]    errCnt;
  logic [LEN_W-1:0]    lenMinusOne;
  logic [CW_W-1:0]     nextCtrl;

  tdTokenDecode u_dec (
    .token    (inToken),
    .pid      (decPid),
    .devAddr  (decAddr),
    .endp     (decEndp),
    .maxLen   (decMax),
    .pidOk    (decPidOk),
    .pidIn    (decPidIn),
    .pidSetup (decPidSetup)
  );

  assign errCnt      = inCtrl[ERR_HI:ERR_LO];
  assign lenMinusOne = inLen[LEN_W-1:0] - LEN_W'(1);

  always_comb begin
    flags.active   = inCtrl[BIT_ACT];
    flags.iso      = inCtrl[BIT_ISO];
    flags.ioc      = inCtrl[BIT_IOC];
    flags.spd      = inCtrl[BIT_SPD];
    flags.pidOk    = decPidOk;
    flags.pidIn    = decPidIn;
    flags.pidSetup = decPidSetup;
    flags.overMax  = inLen > {1'b0, decMax};
    flags.underMax = inLen < {1'b0, decMax};
    flags.errZero  = (errCnt == '0);
    flags.errOne   = (errCnt == ERR_W'(1));
  end

  always_comb begin
    nextCtrl = inCtrl;
    if (strobe.wrLen)      nextCtrl[LEN_W-1:0]     = lenMinusOne;
    if (strobe.decErr)     nextCtrl[ERR_HI:ERR_LO] = errCnt - ERR_W'(1);
    if (strobe.setStall)   nextCtrl[BIT_STALL]     = 1'b1;
    if (strobe.setBabble)  nextCtrl[BIT_BAB]       = 1'b1;
    if (strobe.setTimeout) nextCtrl[BIT_TO]        = 1'b1;
    if (strobe.setNak)     nextCtrl[BIT_NAK]       = 1'b1;
    if (strobe.clrNak)     nextCtrl[BIT_NAK]       = 1'b0;
    if (strobe.clrActive)  nextCtrl[BIT_ACT]       = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outCtrl   <= '0;
      outCause  <= '0;
      outResult <= RES_DONE;
      outPid    <= '0;
      outAddr   <= '0;
      outEndp   <= '0;
      outMaxLen <= '0;
      outBadPid <= 1'b0;
    end else if (strobe.load) begin
      outCtrl   <= nextCtrl;
      outCause  <= strobe.cause;
      outResult <= strobe.result;
      outPid    <= decPid;
      outAddr   <= decAddr;
      outEndp   <= decEndp;
      outMaxLen <= decMax;
      outBadPid <= !decPidOk;
    end
  end
endmodule

// File: rtl/tdStatusUnit.sv
module tdStatusUnit
  import tdStatusPkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  output logic                inReady,
  input  logic [CW_W-1:0]     inCtrl,
  input  logic [CW_W-1:0]     inToken,
  input  logic [2:0]          inKind,
  input  logic [BYTE_W-1:0]   inLen,
  output logic                outValid,
  input  logic                outReady,
  output logic [CW_W-1:0]     outCtrl,
  output logic [CAUSE_W-1:0]  outCause,
  output logic [1:0]          outResult,
  output logic [PID_W-1:0]    outPid,
  output logic [TOK_AD_W-1:0] outAddr,
  output logic [TOK_EP_W-1:0] outEndp,
  output logic [LEN_W-1:0]    outMaxLen,
  output logic                outBadPid
);
  tdFlags_t  flags;
  tdStrobe_t strobe;
  result_e   resultReg;

  tdStatusCtrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .flags    (flags),
    .kind     (outcome_e'(inKind)),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  tdStatusPath u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .inCtrl    (inCtrl),
    .inToken   (inToken),
    .inLen     (inLen),
    .strobe    (strobe),
    .flags     (flags),
    .outCtrl   (outCtrl),
    .outCause  (outCause),
    .outResult (resultReg),
    .outPid    (outPid),
    .outAddr   (outAddr),
    .outEndp   (outEndp),
    .outMaxLen (outMaxLen),
    .outBadPid (outBadPid)
  );

  assign outResult = resultReg;
endmodule

// File: rtl/tdStatusUnitChk.sv
module tdStatusUnitChk (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic        inReady,
  input logic [31:0] inCtrl,
  input logic [31:0] inToken,
  input logic [2:0]  inKind,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outCtrl,
  input logic [3:0]  outCause,
  input logic [1:0]  outResult,
  input logic [7:0]  outPid,
  input logic        outBadPid
);
  logic fire;
  logic tokOk;
  assign fire  = inValid && inReady;
  assign tokOk = (inToken[7:0] == 8'h2D) || (inToken[7:0] == 8'h69) || (inToken[7:0] == 8'hE1);

  a_r1_bad_pid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outBadPid == !((outPid == 8'h2D) || (outPid == 8'h69) || (outPid == 8'hE1)));

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> outValid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outCtrl) && $stable(outResult) && $stable(outCause)));

  a_r3_inactive_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !inCtrl[23]) |=> (outCtrl == $past(inCtrl) && outResult == 2'd1 && outCause == 4'd0));

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && inCtrl[23] && tokOk && inKind == 3'd1) |=> (outCtrl[22] && !outCtrl[23] && outResult == 2'd1));

  a_r8_babble: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && inCtrl[23] && tokOk && inKind == 3'd2) |=> (outCtrl[20] && outCtrl[22] && !outCtrl[23] && outResult == 2'd3));

  a_r11_iso_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && inCtrl[23] && inCtrl[25] && tokOk && inKind != 3'd5) |=> !outCtrl[23]);

  a_r12_bad_pid_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && inCtrl[23] && !tokOk) |=> (outCause[3] && outResult == 2'd3 && outCtrl == $past(inCtrl)));

  a_r13_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && inCtrl[23] && tokOk && inKind == 3'd5) |=> (outResult == 2'd2 && outCause == 4'd0 && outCtrl == $past(inCtrl)));
endmodule

bind tdStatusUnit tdStatusUnitChk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .inReady   (inReady),
  .inCtrl    (inCtrl),
  .inToken   (inToken),
  .inKind    (inKind),
  .outValid  (outValid),
  .outReady  (outReady),
  .outCtrl   (outCtrl),
  .outCause  (outCause),
  .outResult (outResult),
  .outPid    (outPid),
  .outBadPid (outBadPid)
);

// File: tb/tdStatusUnit_tb.sv
`timescale 1ns/1ps
module tdStatusUnit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inCtrl = '0;
  logic [31:0] inToken = '0;
  logic [2:0]  inKind = '0;
  logic [11:0] inLen = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outCtrl;
  logic [3:0]  outCause;
  logic [1:0]  outResult;
  logic [7:0]  outPid;
  logic [6:0]  outAddr;
  logic [3:0]  outEndp;
  logic [10:0] outMaxLen;
  logic        outBadPid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tdStatusUnit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inCtrl(inCtrl), .inToken(inToken), .inKind(inKind), .inLen(inLen),
    .outValid(outValid), .outReady(outReady), .outCtrl(outCtrl),
    .outCause(outCause), .outResult(outResult), .outPid(outPid),
    .outAddr(outAddr), .outEndp(outEndp), .outMaxLen(outMaxLen),
    .outBadPid(outBadPid)
  );

  // tokens: IN max 64 addr 5 ep 1; OUT max 8 addr 3; SETUP max 8; IN max 0 addr 2; bad PID 0xA5
  localparam logic [31:0] T_IN64  = 32'h07E08569;
  localparam logic [31:0] T_OUT8  = 32'h00E003E1;
  localparam logic [31:0] T_SET8  = 32'h00E0032D;
  localparam logic [31:0] T_IN0   = 32'hFFE00269;
  localparam logic [31:0] T_BAD   = 32'h00E003A5;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] ctrl;
    logic [31:0] tok;
    logic [2:0]  kind;
    logic [11:0] len;
    logic [31:0] eCtrl;
    logic [3:0]  eCause;
    logic [1:0]  eRes;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  32'h198807FF, T_IN64, 3'd0, 12'd64, 32'h1900003F, 4'h1, 2'd0}, // R4 success, NAK cleared
    '{4'd5,  32'h388007FF, T_IN64, 3'd0, 12'd10, 32'h38000009, 4'h2, 2'd1}, // R5 short packet
    '{4'd5,  32'h388007FF, T_IN64, 3'd0, 12'd64, 32'h3800003F, 4'h0, 2'd0}, // R5 full length
    '{4'd4,  32'h01800000, T_IN0,  3'd0, 12'd0,  32'h010007FF, 4'h1, 2'd0}, // R4 zero length wraps
    '{4'd6,  32'h18800000, T_IN64, 3'd0, 12'd65, 32'h18500000, 4'h0, 2'd3}, // R6 IN overlength
    '{4'd6,  32'h00800000, T_OUT8, 3'd0, 12'd9,  32'h00000008, 4'h0, 2'd0}, // R6 OUT not babble
    '{4'd7,  32'h18800000, T_OUT8, 3'd1, 12'd0,  32'h18400000, 4'h0, 2'd1}, // R7 stall
    '{4'd8,  32'h19800000, T_IN64, 3'd2, 12'd0,  32'h19500000, 4'h0, 2'd3}, // R8 babble
    '{4'd9,  32'h18800000, T_IN64, 3'd3, 12'd0,  32'h18880000, 4'h0, 2'd1}, // R9 NAK stays active
    '{4'd9,  32'h18800000, T_SET8, 3'd3, 12'd0,  32'h108C0000, 4'h0, 2'd1}, // R9 NAK on SETUP
    '{4'd10, 32'h18800000, T_IN64, 3'd4, 12'd0,  32'h10840000, 4'h0, 2'd1}, // R10 counter 3 to 2
    '{4'd10, 32'h09800000, T_IN64, 3'd4, 12'd0,  32'h01040000, 4'h5, 2'd1}, // R10 counter 1 to 0
    '{4'd10, 32'h00800000, T_IN64, 3'd4, 12'd0,  32'h00840000, 4'h0, 2'd1}, // R10 counter at 0
    '{4'd10, 32'h10800000, T_OUT8, 3'd7, 12'd0,  32'h08840000, 4'h0, 2'd1}, // R10 reserved kind
    '{4'd11, 32'h02800000, T_OUT8, 3'd0, 12'd8,  32'h02000007, 4'h0, 2'd0}, // R11 iso success
    '{4'd11, 32'h02800000, T_IN64, 3'd3, 12'd0,  32'h02080000, 4'h0, 2'd1}, // R11 iso NAK
    '{4'd12, 32'h19800000, T_BAD,  3'd0, 12'd4,  32'h19800000, 4'h8, 2'd3}, // R12 bad PID
    '{4'd3,  32'h19000123, T_IN64, 3'd1, 12'd0,  32'h19000123, 4'h0, 2'd1}, // R3 inactive
    '{4'd3,  32'h00000005, T_BAD,  3'd0, 12'd3,  32'h00000005, 4'h0, 2'd1}, // R3 inactive bad PID
    '{4'd13, 32'h19800000, T_IN64, 3'd5, 12'd0,  32'h19800000, 4'h0, 2'd2}, // R13 pending
    '{4'd13, 32'h02800000, T_OUT8, 3'd5, 12'd0,  32'h02800000, 4'h0, 2'd2}  // R13 iso pending
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    inCtrl  = v.ctrl;
    inToken = v.tok;
    inKind  = v.kind;
    inLen   = v.len;
  endtask

  task automatic checkVec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    chk({tag, " valid"},  32'(outValid),  32'd1);
    chk({tag, " ctrl"},   outCtrl,        v.eCtrl);
    chk({tag, " cause"},  32'(outCause),  32'(v.eCause));
    chk({tag, " result"}, 32'(outResult), 32'(v.eRes));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset outValid", 32'(outValid), 32'd0);
    chk("R2 reset inReady",  32'(inReady),  32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      checkVec(VECS[i]);
      if (i == 0) begin
        chk("R1 pid",    32'(outPid),    32'h69);
        chk("R1 addr",   32'(outAddr),   32'd5);
        chk("R1 endp",   32'(outEndp),   32'd1);
        chk("R1 maxLen", 32'(outMaxLen), 32'd64);
        chk("R1 badPid", 32'(outBadPid), 32'd0);
      end
      if (i == 3) begin
        chk("R1 zero maxLen", 32'(outMaxLen), 32'd0);
        chk("R1 addr2",       32'(outAddr),   32'd2);
      end
      if (i == 16) begin
        chk("R1 bad flag", 32'(outBadPid), 32'd1);
        chk("R1 bad pid",  32'(outPid),    32'hA5);
      end
      if (i == 9) chk("R1 setup ok", 32'(outBadPid), 32'd0);
    end

    // R2 backpressure: result held while a second request waits
    @(negedge clk);
    chk("R2 idle drains", 32'(outValid), 32'd0);
    outReady = 1'b0;
    drive(VECS[0]);
    inValid = 1'b1;
    @(negedge clk);
    chk("R2 inReady low", 32'(inReady), 32'd0);
    chk("R2 first ctrl", outCtrl, VECS[0].eCtrl);
    drive(VECS[6]);
    @(negedge clk);
    chk("R2 held ctrl", outCtrl, VECS[0].eCtrl);
    chk("R2 held valid", 32'(outValid), 32'd1);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkVec(VECS[6]);
    @(negedge clk);
    chk("R2 consumed", 32'(outValid), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule